// File: doc/BRIEF.md
# Per-Core Programmable Countdown Timer

This block is the timer of a per-core interrupt controller. Software programs it through a plain 32-bit register port: an entry word that holds the interrupt vector, a mask flag and the run mode; a 4-bit divide code that sets how many clocks make one count; and a start value. Writing the start value loads the live count and restarts the prescaler. The count then drops by one on every divided tick.

When the count reaches zero the block emits a one-cycle interrupt request together with the programmed vector, unless the entry is masked. A masked timer still counts. In repeat mode the count reloads from the stored start value and runs again. In single-shot mode it stays at zero until software writes a new start value. Writing a start value of zero halts the timer. Software can read the remaining count at any time.

Top module: `core_countdown_timer`

## Requirements
- R1: After reset the request output is low and its vector is 0. The entry word reads 0x0001_0000 (masked, single-shot, vector 0). The start value, the live count and the divide code all read 0.
- R2: The entry word at offset 0x320 holds the vector in bits 7:0, the mask flag in bit 16 and the mode in bits 18:17. All other bits read 0. Setting or clearing the mask with a read-modify-write leaves the vector and the mode unchanged.
- R3: The divide code at offset 0x3E0 uses bits 3:0. Bit 2 is ignored and reads 0. The codes map as follows: 0x0 gives ÷2, 0x1 ÷4, 0x2 ÷8, 0x3 ÷16, 0x8 ÷32, 0x9 ÷64, 0xA ÷128 and 0xB ÷1.
- R4: A write of N to the start value at 0x380 loads the count and resets the prescaler. With divisor D, the first request appears in the cycle that follows the (N·D)-th clock edge after the write edge.
- R5: Writing 0 to the start value halts the timer. The count then reads 0 and no request follows.
- R6: The live count at 0x390 is read-only. Writes to it have no effect. Reads return the remaining count, which falls by one per tick.
- R7: In single-shot mode (bits 18:17 = 00) the request is a single-cycle pulse carrying the vector. After it, the count stays at 0 with no further pulse. Mode codes 10 and 11 behave as single-shot. The vector output is 0 whenever no request is raised.
- R8: In repeat mode (bits 18:17 = 01) the count reloads from the stored start value as it expires. A request is raised every N·D cycles.
- R9: When the mask flag is set no request is raised, but the count keeps falling.
- R10: A new divide code written while the timer runs takes effect only at the next tick boundary.
- R11: A read of any unmapped offset returns 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request, 0 otherwise |

## Verification
Reads are combinational, so the bench samples a register 1 ns after it sets the address, between two falling edges. A register write takes effect at the rising edge that ends its strobe cycle. The bench takes that edge as time zero by snapshotting a free-running edge counter at the next falling edge. It then expects the request at exactly N·D edges later, and the live count to read N−k after k edges. For the divide change and the prescaler restart, the expected delay is worked out edge by edge from the rule that the prescaler counts to D−1 before each tick. The bench samples the request only on falling edges, so a pulse that comes early, comes late or lasts two cycles each gives a distinct mismatch.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

  // Register byte offsets on the 32-bit port
  localparam logic [11:0] OFS_ENTRY = 12'h320;
  localparam logic [11:0] OFS_START = 12'h380;
  localparam logic [11:0] OFS_LIVE  = 12'h390;
  localparam logic [11:0] OFS_DIV   = 12'h3E0;

  // Field placement in the entry word
  localparam int MASK_BIT = 16;
  localparam int MODE_LSB = 17;

  // Prescaler sizing: exponent 0..7 selects divisor 1..128
  localparam int EXP_W   = 3;
  localparam int PRESC_W = (1 << EXP_W) - 1;

  // Divide code bits that are stored (bit 2 is dropped)
  localparam logic [3:0] DIV_KEEP = 4'hB;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_RSV_A  = 2'b10,
    MODE_RSV_B  = 2'b11
  } tmr_mode_e;

  // Code {b3,b1,b0} plus one, modulo eight, is the log2 of the divisor
  function automatic logic [EXP_W-1:0] div_exponent(input logic [3:0] code);
    logic [EXP_W-1:0] idx;
    idx = {code[3], code[1:0]};
    return idx + EXP_W'(1);
  endfunction

endpackage

// File: rtl/ltmr_regs.sv
module ltmr_regs
  import ltmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] live_cnt,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [VEC_W-1:0]  vector,
  output logic              mask,
  output logic              periodic,
  output logic [EXP_W-1:0]  div_exp,
  output logic [DATA_W-1:0] start_val,
  output logic              start_wr
);

  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              mask_q, mask_d;
  tmr_mode_e         mode_q, mode_d;
  logic [3:0]        div_q, div_d;
  logic [DATA_W-1:0] start_q, start_d;
  logic              hit_entry, hit_div, hit_start;

  // Write decode and next-state
  always_comb begin
    hit_entry = bus_wr && (bus_addr == ADDR_W'(OFS_ENTRY));
    hit_div   = bus_wr && (bus_addr == ADDR_W'(OFS_DIV));
    hit_start = bus_wr && (bus_addr == ADDR_W'(OFS_START));
    vec_d     = bus_wdata[VEC_W-1:0];
    mask_d    = bus_wdata[MASK_BIT];
    mode_d    = tmr_mode_e'(bus_wdata[MODE_LSB +: 2]);
    div_d     = bus_wdata[3:0] & DIV_KEEP;
    start_d   = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      mask_q  <= 1'b1;
      mode_q  <= MODE_ONCE;
      div_q   <= '0;
      start_q <= '0;
    end else begin
      if (hit_entry) begin
        vec_q  <= vec_d;
        mask_q <= mask_d;
        mode_q <= mode_d;
      end
      if (hit_div)   div_q   <= div_d;
      if (hit_start) start_q <= start_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_ENTRY): begin
        bus_rdata[VEC_W-1:0]      = vec_q;
        bus_rdata[MASK_BIT]       = mask_q;
        bus_rdata[MODE_LSB +: 2]  = mode_q;
      end
      ADDR_W'(OFS_DIV):   bus_rdata[3:0] = div_q;
      ADDR_W'(OFS_START): bus_rdata      = start_q;
      ADDR_W'(OFS_LIVE):  bus_rdata      = live_cnt;
      default:            bus_rdata      = '0;
    endcase
  end

  assign vector    = vec_q;
  assign mask      = mask_q;
  assign periodic  = (mode_q == MODE_REPEAT);
  assign div_exp   = div_exponent(div_q);
  assign start_val = start_q;
  assign start_wr  = hit_start;

endmodule

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler
  import ltmr_pkg::*;
#(
  parameter int PW = PRESC_W,
  parameter int EW = EXP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [EW-1:0] exp_sel,
  output logic          tick,
  output logic [EW-1:0] exp_act
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] exp_q, exp_d;
  logic [PW:0]   span;
  logic [PW-1:0] limit;

  always_comb begin
    span  = (PW+1)'(1) << exp_q;
    limit = PW'(span - (PW+1)'(1));
    tick  = run && (cnt_q == limit);
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (restart) begin
      cnt_d = '0;
      exp_d = exp_sel;
    end else if (tick) begin
      cnt_d = '0;
      exp_d = exp_sel;
    end else if (run) begin
      cnt_d = cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign exp_act = exp_q;

endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              tick,
  input  logic              periodic,
  input  logic              mask,
  input  logic [VEC_W-1:0]  vector,
  output logic [DATA_W-1:0] live_cnt,
  output logic              running,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);

  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              irq_q, irq_d;
  logic [VEC_W-1:0]  vec_q, vec_d;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    vec_d = '0;
    if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      if (cnt_q == DATA_W'(1)) begin
        cnt_d = periodic ? reload_val : '0;
        irq_d = !mask;
        vec_d = mask ? '0 : vector;
      end else begin
        cnt_d = cnt_q - DATA_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      vec_q <= vec_d;
    end
  end

  assign live_cnt   = cnt_q;
  assign running    = (cnt_q != '0);
  assign irq_pulse  = irq_q;
  assign irq_vector = vec_q;

endmodule

// File: rtl/core_countdown_timer.sv
module core_countdown_timer
  import ltmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [VEC_W-1:0]  vector;
  logic              mask;
  logic              periodic;
  logic [EXP_W-1:0]  div_exp_sel;
  logic [EXP_W-1:0]  div_exp_act;
  logic [DATA_W-1:0] start_val;
  logic              init_wr;
  logic [DATA_W-1:0] cur_cnt;
  logic              running;
  logic              tick;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ltmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .live_cnt  (cur_cnt),
    .bus_rdata (bus_rdata),
    .vector    (vector),
    .mask      (mask),
    .periodic  (periodic),
    .div_exp   (div_exp_sel),
    .start_val (start_val),
    .start_wr  (init_wr)
  );

  ltmr_prescaler #(.PW(PRESC_W), .EW(EXP_W)) i_presc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (running),
    .restart (init_wr),
    .exp_sel (div_exp_sel),
    .tick    (tick),
    .exp_act (div_exp_act)
  );

  ltmr_counter #(.DATA_W(DATA_W), .VEC_W(VEC_W)) i_count (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (init_wr),
    .load_val   (bus_wdata),
    .reload_val (start_val),
    .tick       (tick),
    .periodic   (periodic),
    .mask       (mask),
    .vector     (vector),
    .live_cnt   (cur_cnt),
    .running    (running),
    .irq_pulse  (irq_pulse),
    .irq_vector (irq_vector)
  );

endmodule

// File: rtl/ltmr_checker.sv
module ltmr_checker #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8,
  parameter int EW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_pulse,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [DATA_W-1:0] cur_cnt,
  input logic              init_wr,
  input logic              tick,
  input logic              mask,
  input logic              periodic,
  input logic [EW-1:0]     div_exp_act
);

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> !irq_pulse);

  assert_halted_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cnt == '0) |=> !irq_pulse);

  assert_pulse_after_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(cur_cnt) == DATA_W'(1)));

  assert_vector_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> (irq_vector == '0));

  assert_count_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_wr && !(tick && periodic)) |=> (cur_cnt <= $past(cur_cnt)));

  assert_divisor_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !init_wr) |=> $stable(div_exp_act));

  assert_tick_while_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cur_cnt != '0));

endmodule

bind core_countdown_timer ltmr_checker #(
  .DATA_W (DATA_W),
  .VEC_W  (VEC_W),
  .EW     (ltmr_pkg::EXP_W)
) i_ltmr_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .irq_pulse   (irq_pulse),
  .irq_vector  (irq_vector),
  .cur_cnt     (cur_cnt),
  .init_wr     (init_wr),
  .tick        (tick),
  .mask        (mask),
  .periodic    (periodic),
  .div_exp_act (div_exp_act)
);

// File: tb/test_core_countdown_timer.sv
`timescale 1ns/1ps
module test_core_countdown_timer;

  localparam logic [11:0] A_ENTRY = 12'h320;
  localparam logic [11:0] A_START = 12'h380;
  localparam logic [11:0] A_LIVE  = 12'h390;
  localparam logic [11:0] A_DIV   = 12'h3E0;

  // {div code[3:0], start N[7:0], expected delay[15:0], vector[7:0]}
  localparam int NVEC = 10;
  localparam logic [35:0] VEC_TBL [NVEC] = '{
    {4'hB, 8'd5, 16'd5,   8'h10},
    {4'h0, 8'd3, 16'd6,   8'h11},
    {4'h1, 8'd3, 16'd12,  8'h12},
    {4'h2, 8'd2, 16'd16,  8'h13},
    {4'h3, 8'd2, 16'd32,  8'h14},
    {4'h8, 8'd2, 16'd64,  8'h15},
    {4'h9, 8'd1, 16'd64,  8'h16},
    {4'hA, 8'd2, 16'd256, 8'h17},
    {4'h4, 8'd3, 16'd6,   8'h18},
    {4'hF, 8'd4, 16'd4,   8'h19}
  };

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  core_countdown_timer i_core_countdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands at the next rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int t0, output int d);
    while (!irq_pulse && (cyc - t0) < 3000) @(negedge clk);
    d = irq_pulse ? (cyc - t0) : -1;
  endtask

  task automatic count_pulses(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_pulse) p++;
    end
  endtask

  initial begin
    #(8ns * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t0;
    int d;
    int p;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq_pulse}, 32'h0);
    chk("R1 vector", {24'b0, irq_vector}, 32'h0);
    rd(A_ENTRY, v); chk("R1 entry", v, 32'h0001_0000);
    rd(A_START, v); chk("R1 start", v, 32'h0);
    rd(A_LIVE, v);  chk("R1 live", v, 32'h0);
    rd(A_DIV, v);   chk("R1 div", v, 32'h0);

    // R2 field layout and read-modify-write of the mask
    @(negedge clk);
    wr(A_ENTRY, 32'hFFFF_FFFF);
    rd(A_ENTRY, v); chk("R2 unused bits zero", v, 32'h0007_00FF);
    @(negedge clk);
    wr(A_ENTRY, 32'h0002_00AB);
    rd(A_ENTRY, v); chk("R2 entry", v, 32'h0002_00AB);
    @(negedge clk);
    wr(A_ENTRY, v | 32'h0001_0000);
    rd(A_ENTRY, v); chk("R2 mask set", v, 32'h0003_00AB);
    @(negedge clk);
    wr(A_ENTRY, v & ~32'h0001_0000);
    rd(A_ENTRY, v); chk("R2 mask clear", v, 32'h0002_00AB);

    // R11 unmapped offsets
    @(negedge clk);
    wr(12'h300, 32'hFFFF_FFFF);
    rd(A_ENTRY, v); chk("R11 entry untouched", v, 32'h0002_00AB);
    rd(12'h324, v); chk("R11 unmapped read", v, 32'h0);

    // R3 R4 R7 table of divide codes in single-shot mode
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]  code;
      logic [7:0]  n;
      logic [15:0] dly;
      logic [7:0]  vec;
      {code, n, dly, vec} = VEC_TBL[i];
      @(negedge clk);
      wr(A_ENTRY, {24'h0, vec});
      wr(A_DIV, {28'h0, code});
      rd(A_DIV, v); chk("R3 div readback", v, {28'h0, code & 4'hB});
      @(negedge clk);
      wr(A_START, {24'h0, n});
      t0 = cyc;
      wait_irq(t0, d);
      chk("R3 R4 delay", d, {16'h0, dly});
      chk("R7 vector", {24'b0, irq_vector}, {24'h0, vec});
      @(negedge clk);
      chk("R7 single cycle", {31'b0, irq_pulse}, 32'h0);
      rd(A_LIVE, v); chk("R7 stays zero", v, 32'h0);
    end

    // R6 live count, read-only
    @(negedge clk);
    wr(A_ENTRY, 32'h0000_0021);
    wr(A_DIV, 32'hB);
    wr(A_START, 32'd10);
    t0 = cyc;
    rd(A_LIVE, v); chk("R6 live k0", v, 32'd10);
    repeat (3) @(negedge clk);
    rd(A_LIVE, v); chk("R6 live k3", v, 32'd7);
    wr(A_LIVE, 32'h55);
    rd(A_LIVE, v); chk("R6 write ignored", v, 32'd6);
    wait_irq(t0, d);
    chk("R6 delay unchanged", d, 32'd10);

    // R7 reserved mode behaves as single-shot
    @(negedge clk);
    wr(A_ENTRY, 32'h0006_0077);
    wr(A_START, 32'd3);
    t0 = cyc;
    wait_irq(t0, d);
    chk("R7 mode11 delay", d, 32'd3);
    count_pulses(8, p);
    chk("R7 mode11 no repeat", p, 32'd0);

    // R8 repeat mode, divide by 2
    @(negedge clk);
    wr(A_ENTRY, 32'h0002_005A);
    wr(A_DIV, 32'h0);
    wr(A_START, 32'd3);
    t0 = cyc;
    for (int k = 0; k < 3; k++) begin
      wait_irq(t0, d);
      chk("R8 period", d, 32'd6);
      chk("R8 vector", {24'b0, irq_vector}, 32'h5A);
      rd(A_LIVE, v); chk("R8 reload", v, 32'd3);
      t0 = cyc;
      @(negedge clk);
    end
    wr(A_START, 32'd0);

    // R9 masked counting
    @(negedge clk);
    wr(A_ENTRY, 32'h0001_0033);
    wr(A_DIV, 32'hB);
    wr(A_START, 32'd5);
    repeat (2) @(negedge clk);
    rd(A_LIVE, v); chk("R9 counts while masked", v, 32'd3);
    count_pulses(10, p);
    chk("R9 no request", p, 32'd0);
    rd(A_LIVE, v); chk("R9 reached zero", v, 32'd0);
    rd(A_ENTRY, v);
    @(negedge clk);
    wr(A_ENTRY, v & ~32'h0001_0000);
    wr(A_START, 32'd2);
    t0 = cyc;
    wait_irq(t0, d);
    chk("R9 unmasked delay", d, 32'd2);
    chk("R9 unmasked vector", {24'b0, irq_vector}, 32'h33);

    // R5 halt by writing zero
    @(negedge clk);
    wr(A_ENTRY, 32'h0000_0044);
    wr(A_START, 32'd6);
    wr(A_START, 32'd0);
    count_pulses(15, p);
    chk("R5 no request", p, 32'd0);
    rd(A_LIVE, v); chk("R5 count zero", v, 32'd0);

    // R4 restart resets the prescaler (divide by 4)
    @(negedge clk);
    wr(A_DIV, 32'h1);
    wr(A_START, 32'd5);
    repeat (2) @(negedge clk);
    wr(A_START, 32'd2);
    t0 = cyc;
    wait_irq(t0, d);
    chk("R4 restart delay", d, 32'd8);

    // R10 divide change waits for the tick boundary
    @(negedge clk);
    wr(A_DIV, 32'h1);
    wr(A_START, 32'd3);
    t0 = cyc;
    wr(A_DIV, 32'hB);
    wait_irq(t0, d);
    chk("R10 boundary delay", d, 32'd6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule